// File: doc/BRIEF.md
# Register-to-Register Integer Execute Unit

This block takes one 32-bit instruction word per clock and carries it out in that same clock. It decodes the instruction, reads its source operands from an internal bank of 32 general registers of 32 bits each, computes the result and writes it back. The instruction subset covers three register-to-register operations: add, subtract and signed set-on-less-than. It also covers five operations that take a 16-bit constant from the instruction: add, signed set-on-less-than, bitwise AND, bitwise OR and upper-half load. A constant of the full 32 bits is built from two instructions: an upper-half load followed by an OR-with-constant on the same register.

The instruction port has no handshake. A word is executed only in a cycle where its valid strobe is high. The result of each instruction appears on registered write-back outputs one cycle later, together with a flag for words that fall outside the subset. A separate debug port reads any register. Its data appears one cycle after the address is applied.

Top module: `rx_exec_unit`

## Requirements
- R1: After a synchronous reset, `illegal_o` and `wb_valid_o` are 0, and every register reads back as 0 through the debug port.
- R2: Register 0 always reads as 0. An instruction whose destination is register 0 changes no register and leaves `wb_valid_o` low.
- R3: A word with op field [31:26]=0 and function field [5:0]=32 writes rs+rt, modulo 2^32, into rd. The fields are rs [25:21], rt [20:16] and rd [15:11].
- R4: Op 0 with function 34 writes rs−rt, modulo 2^32, into rd.
- R5: Op 0 with function 42 writes 1 into rd when rs is less than rt as a signed two's-complement number, and 0 otherwise.
- R6: Op 8 writes rs plus the sign-extended immediate [15:0] into rt. Overflow wraps.
- R7: Op 10 writes 1 into rt when rs is less than the sign-extended immediate, compared as signed values, and 0 otherwise.
- R8: Op 12 writes rs AND the zero-extended immediate into rt. Op 13 writes rs OR the zero-extended immediate into rt.
- R9: Op 15 writes the immediate into bits 31:16 of rt and clears bits 15:0. A following op-13 instruction on the same register completes a full 32-bit constant.
- R10: Each of the following sets `illegal_o` to 1 in the cycle after the instruction, leaves `wb_valid_o` low and changes no register:
  - any op value other than 0, 8, 10, 12, 13 and 15;
  - op 0 with a function value other than 32, 34 and 42;
  - op 0 with a nonzero shamt field [10:6].
- R11: While `instr_valid` is low, the instruction word has no effect. In the next cycle no register changes and both flags are low.
- R12: For every executed write, `wb_valid_o`, `wb_addr_o` and `wb_data_o` show the destination and the value in the following cycle.
- R13: `dbg_data` shows the register selected by `dbg_addr` one cycle after the address is applied.
- R14: An instruction issued in the cycle right after another sees that instruction's result as its source operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Execute `instr_word` this cycle |
| instr_word | input | 32 | Instruction to execute |
| dbg_addr | input | 5 | Register to read on the debug port |
| dbg_data | output | 32 | Registered contents of the selected register |
| illegal_o | output | 1 | Previous cycle's instruction was outside the subset |
| wb_valid_o | output | 1 | Previous cycle wrote a register |
| wb_addr_o | output | 5 | Destination of that write |
| wb_data_o | output | 32 | Value of that write |

## Verification
The assertions check these rules on every cycle:
- a cycle without a valid word produces neither a write-back nor an illegal flag;
- a write-back never names register 0;
- an illegal flag never coincides with a write-back;
- a set-on-less-than result is 0 or 1;
- an upper-half load leaves the low half clear;
- the debug port returns 0 for register 0.

The arithmetic values themselves can only be shown by the directed scenarios. These include signed comparisons across the sign boundary and wrap-around on overflow. The scenarios also cover the width of immediate extension, two-instruction constants, that an illegal word leaves the register unchanged, and forwarding from one instruction to the next.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX   = $clog2(NREG);
  localparam int IMMW   = 16;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;
  localparam logic [5:0] FN_SLT   = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN, EXT_ZERO, EXT_HIGH
  } ext_mode_e;

  typedef struct packed {
    alu_op_e         op;
    logic            use_imm;
    ext_mode_e       ext;
    logic [RIDX-1:0] dest;
    logic            illegal;
    logic            we;
  } ctrl_t;
endpackage

// File: rtl/rx_decode.sv
module rx_decode
  import rx_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] word,
  output ctrl_t       ctrl
);
  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [4:0]      sh;
  logic [RIDX-1:0] f_rt;
  logic [RIDX-1:0] f_rd;

  assign opc  = word[31:26];
  assign fn   = word[5:0];
  assign sh   = word[10:6];
  assign f_rt = word[20:16];
  assign f_rd = word[15:11];

  always_comb begin
    ctrl         = '0;
    ctrl.op      = ALU_ADD;
    ctrl.ext     = EXT_SIGN;
    ctrl.use_imm = 1'b1;
    ctrl.dest    = f_rt;
    unique case (opc)
      OP_RTYPE: begin
        ctrl.use_imm = 1'b0;
        ctrl.dest    = f_rd;
        case (fn)
          FN_ADD:  ctrl.op = ALU_ADD;
          FN_SUB:  ctrl.op = ALU_SUB;
          FN_SLT:  ctrl.op = ALU_SLT;
          default: ctrl.illegal = 1'b1;
        endcase
        if (sh != 5'd0) ctrl.illegal = 1'b1;
      end
      OP_ADDI: ctrl.op = ALU_ADD;
      OP_SLTI: ctrl.op = ALU_SLT;
      OP_ANDI: begin ctrl.op = ALU_AND;   ctrl.ext = EXT_ZERO; end
      OP_ORI:  begin ctrl.op = ALU_OR;    ctrl.ext = EXT_ZERO; end
      OP_LUI:  begin ctrl.op = ALU_PASSB; ctrl.ext = EXT_HIGH; end
      default: ctrl.illegal = 1'b1;
    endcase
    ctrl.illegal = ctrl.illegal & valid;
    ctrl.we      = valid & ~ctrl.illegal & (ctrl.dest != '0);
  end
endmodule

// File: rtl/rx_regfile.sv
module rx_regfile
  import rx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RIDX-1:0] ra_a,
  input  logic [RIDX-1:0] ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] dbg_addr,
  output logic [XLEN-1:0] dbg_data
);
  logic [XLEN-1:0] mem [NREG];
  logic [NREG-1:0] live;

  function automatic logic [XLEN-1:0] rd_port(input logic [RIDX-1:0] a,
                                              input logic [NREG-1:0] lv,
                                              input logic [XLEN-1:0] v);
    return (a == '0 || !lv[a]) ? '0 : v;
  endfunction

  assign rd_a = rd_port(ra_a, live, mem[ra_a]);
  assign rd_b = rd_port(ra_b, live, mem[ra_b]);

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= '0;
      dbg_data <= '0;
    end else begin
      if (we && waddr != '0) live[waddr] <= 1'b1;
      dbg_data <= rd_port(dbg_addr, live, mem[dbg_addr]);
    end
  end

  p_dbg_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (dbg_addr == '0) |=> (dbg_data == '0))
    else $error("debug read of register 0 not zero");
endmodule

// File: rtl/rx_alu.sv
module rx_alu
  import rx_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
  import rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_valid,
  input  logic [31:0] instr_word,
  input  logic [4:0]  dbg_addr,
  output logic [31:0] dbg_data,
  output logic        illegal_o,
  output logic        wb_valid_o,
  output logic [4:0]  wb_addr_o,
  output logic [31:0] wb_data_o
);
  ctrl_t           ctl;
  logic [XLEN-1:0] src_a, src_b, imm_x, opnd_b, result;
  logic [IMMW-1:0] imm;

  assign imm = instr_word[IMMW-1:0];

  rx_decode u_dec (.valid(instr_valid), .word(instr_word), .ctrl(ctl));

  rx_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra_a(instr_word[25:21]), .ra_b(instr_word[20:16]),
    .rd_a(src_a), .rd_b(src_b),
    .we(ctl.we), .waddr(ctl.dest), .wdata(result),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  always_comb begin
    unique case (ctl.ext)
      EXT_ZERO: imm_x = {{(XLEN-IMMW){1'b0}}, imm};
      EXT_HIGH: imm_x = {imm, {(XLEN-IMMW){1'b0}}};
      default:  imm_x = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    endcase
  end

  assign opnd_b = ctl.use_imm ? imm_x : src_b;

  rx_alu u_alu (.op(ctl.op), .a(src_a), .b(opnd_b), .y(result));

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_o  <= 1'b0;
      wb_valid_o <= 1'b0;
      wb_addr_o  <= '0;
      wb_data_o  <= '0;
    end else begin
      illegal_o  <= ctl.illegal;
      wb_valid_o <= ctl.we;
      if (ctl.we) begin
        wb_addr_o <= ctl.dest;
        wb_data_o <= result;
      end
    end
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!wb_valid_o && !illegal_o))
    else $error("activity without a valid instruction");

  p_no_zero_dest_r2: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> (wb_addr_o != 5'd0))
    else $error("write-back reported for register 0");

  p_illegal_no_wb_r10: assert property (@(posedge clk) disable iff (rst)
    !(illegal_o && wb_valid_o))
    else $error("illegal instruction produced a write-back");

  p_slt_bool_r5: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_word[31:26] == OP_RTYPE && instr_word[5:0] == FN_SLT
     && instr_word[10:6] == 5'd0 && instr_word[15:11] != 5'd0)
    |=> (wb_valid_o && wb_data_o[31:1] == '0))
    else $error("set-less-than result not boolean");

  p_lui_low_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_word[31:26] == OP_LUI && instr_word[20:16] != 5'd0)
    |=> (wb_valid_o && wb_data_o[15:0] == '0))
    else $error("upper load left low half set");
endmodule

// File: tb/rx_exec_unit_test.sv
`timescale 1ns/1ps
module rx_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        illegal_o, wb_valid_o;
  logic [4:0]  wb_addr_o;
  logic [31:0] wb_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_exec_unit uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .illegal_o(illegal_o),
    .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [31:0] rt_w(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] it_w(input int op, input int rs, input int rt, input logic [15:0] im);
    return {op[5:0], rs[4:0], rt[4:0], im};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    @(negedge clk);
    dbg_addr = a[4:0];
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 illegal after reset", {31'd0, illegal_o}, 0);
    check("R1 wb_valid after reset", {31'd0, wb_valid_o}, 0);
    rd_reg(1, v);  check("R1 r1 reset", v, 0);
    rd_reg(31, v); check("R1 r31 reset", v, 0);
  endtask

  task automatic t_constant;
    logic [31:0] v;
    issue(it_w(15, 0, 8, 16'hABCD));
    check("R9 lui wb_valid", {31'd0, wb_valid_o}, 1);
    check("R12 lui wb_addr", {27'd0, wb_addr_o}, 8);
    check("R9 lui wb_data", wb_data_o, 32'hABCD_0000);
    issue(it_w(13, 8, 8, 16'h1234));
    rd_reg(8, v); check("R9 lui+ori constant", v, 32'hABCD_1234);
    check("R13 debug shows r8", v, 32'hABCD_1234);
  endtask

  task automatic t_addi;
    logic [31:0] v;
    issue(it_w(8, 0, 1, 16'd5));
    rd_reg(1, v); check("R6 addi positive", v, 5);
    issue(it_w(8, 0, 2, 16'hFFFD));
    check("R12 addi wb_data", wb_data_o, 32'hFFFF_FFFD);
    rd_reg(2, v); check("R6 addi sign-extended", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_add;
    logic [31:0] v;
    issue(rt_w(1, 2, 3, 32));
    rd_reg(3, v); check("R3 add 5+(-3)", v, 2);
    issue(it_w(8, 0, 17, 16'd7));
    issue(it_w(8, 0, 18, 16'd9));
    issue(32'b000000_10001_10010_01001_00000_100000);
    rd_reg(9, v); check("R3 add fixed encoding", v, 16);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    issue(it_w(15, 0, 4, 16'h7FFF));
    issue(it_w(13, 4, 4, 16'hFFFF));
    issue(it_w(8, 4, 5, 16'd1));
    rd_reg(5, v); check("R6 addi overflow wraps", v, 32'h8000_0000);
    issue(rt_w(5, 5, 6, 32));
    rd_reg(6, v); check("R3 add overflow wraps", v, 0);
  endtask

  task automatic t_sub;
    logic [31:0] v;
    issue(rt_w(1, 2, 7, 34));
    rd_reg(7, v); check("R4 sub 5-(-3)", v, 8);
    issue(rt_w(2, 1, 7, 34));
    rd_reg(7, v); check("R4 sub -3-5", v, 32'hFFFF_FFF8);
  endtask

  task automatic t_slt;
    logic [31:0] v;
    issue(rt_w(2, 1, 10, 42));
    rd_reg(10, v); check("R5 slt -3<5", v, 1);
    issue(rt_w(1, 2, 10, 42));
    rd_reg(10, v); check("R5 slt 5<-3", v, 0);
    issue(rt_w(5, 1, 11, 42));
    rd_reg(11, v); check("R5 slt min<5 signed", v, 1);
    issue(it_w(10, 1, 12, 16'd6));
    rd_reg(12, v); check("R7 slti 5<6", v, 1);
    issue(it_w(10, 1, 12, 16'hFFFF));
    rd_reg(12, v); check("R7 slti 5<-1", v, 0);
  endtask

  task automatic t_logic;
    logic [31:0] v;
    issue(it_w(12, 8, 13, 16'hFF0F));
    rd_reg(13, v); check("R8 andi", v, 32'h0000_1204);
    issue(it_w(12, 2, 13, 16'h8001));
    rd_reg(13, v); check("R8 andi zero-extended", v, 32'h0000_8001);
    issue(it_w(13, 0, 14, 16'h8000));
    rd_reg(14, v); check("R8 ori zero-extended", v, 32'h0000_8000);
  endtask

  task automatic t_zero_dest;
    logic [31:0] v;
    issue(it_w(8, 0, 0, 16'd9));
    check("R2 no wb to r0", {31'd0, wb_valid_o}, 0);
    issue(rt_w(1, 1, 0, 32));
    rd_reg(0, v); check("R2 r0 reads zero", v, 0);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    issue(rt_w(2, 2, 1, 33));
    check("R10 bad funct flag", {31'd0, illegal_o}, 1);
    check("R10 bad funct no wb", {31'd0, wb_valid_o}, 0);
    issue(it_w(4, 0, 1, 16'd1));
    check("R10 bad op flag", {31'd0, illegal_o}, 1);
    issue(rt_w(2, 2, 1, 32) | 32'h0000_0040);
    check("R10 shamt flag", {31'd0, illegal_o}, 1);
    rd_reg(1, v); check("R10 r1 unchanged", v, 5);
    check("R10 flag clears", {31'd0, illegal_o}, 0);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    @(negedge clk);
    instr_word = it_w(8, 0, 1, 16'd99);
    @(negedge clk);
    check("R11 no wb when idle", {31'd0, wb_valid_o}, 0);
    rd_reg(1, v); check("R11 r1 unchanged", v, 5);
  endtask

  task automatic t_back_to_back;
    logic [31:0] v;
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = it_w(8, 0, 15, 16'd10);
    @(negedge clk);
    instr_word  = rt_w(15, 15, 16, 32);
    @(negedge clk);
    instr_valid = 1'b0;
    check("R14 wb_data of dependent", wb_data_o, 20);
    rd_reg(16, v); check("R14 dependent result", v, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_constant();
    t_addi();
    t_add();
    t_wrap();
    t_sub();
    t_slt();
    t_logic();
    t_zero_dest();
    t_illegal();
    t_idle();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule